// File: doc/BRIEF.md
# Flash Programming Target Behind a Test Access Port

This block sits behind a test access port controller and gives an external debug probe a path into an embedded flash. The port controller is not part of the block. It delivers capture, shift and update strobes for the instruction and data paths, along with the serial input bit. The block returns the serial output bit. An 8-bit instruction selects one of several data registers: a status byte, an 8-bit address, a 64-bit data word, a 32-bit identification value, or a 1-bit bypass cell.

The probe first enters programming mode. It then loads an address, programs 64-bit words, erases sectors under a 64-bit mask, runs blank checks, and reads back the option word. It polls the status byte until the completion flag is set. The flash array is modelled by registers: one non-blank flag per sector, a 64-bit option word and a security flag. Every operation takes a fixed number of clock cycles, set by a parameter.

Top module: `isc_flash_tap_target`

## Requirements
- R1: After reset the current instruction is the identification code (0xFE). A data capture followed by 32 shifts returns the ID_CODE parameter, least significant bit first. The status byte reads 0x04.
- R2: Instruction 0x10 selects the 8-bit status byte. Bit 6 is the security flag, bits 5:4 are internal error (always 0), bit 3 is programming mode active, bit 2 is operation complete, and bits 1:0 are the result code (0 none, 1 invalid instruction, 2 success, 3 mode inactive). Bit 7 is 0.
- R3: An instruction update to 0x0C sets the mode-active flag. An update to 0x0F clears it.
- R4: Instruction 0x11 loads an 8-bit address on data update. Program (0x20) takes a 64-bit word on data update. An address below 64 marks that sector non-blank. Address 0x50 replaces the option word, which instruction 0x07 captures as 64 bits.
- R5: Blank check (0x60) takes a 64-bit sector mask. On completion, the 64-bit register captured under 0x60 holds the AND of the mask and the non-blank flags, so a set bit marks a non-blank sector.
- R6: Erase (0x30) takes a 64-bit mask. All 64 bits set clears every sector, the option word and the security flag. Exactly bit 49 set clears only the option word. Any other mask marks the selected sectors blank.
- R7: An instruction update to 0x22 starts a security operation that sets the security flag on completion.
- R8: Program, erase, blank check or security requested while the mode is inactive starts nothing, leaves the completion flag set and sets result code 3.
- R9: An accepted operation clears the completion flag on its start edge. The flag sets exactly BUSY_CYCLES clock edges later, and at that same edge the result code becomes 2.
- R10: Any instruction outside the recognised set selects a 1-bit bypass cell that captures 0. When no operation is in flight, such an instruction sets result code 1.
- R11: An instruction update to 0x13 while idle sets the result code to 0.
- R12: While an operation is in flight, further operation requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data in |
| ir_capture | input | 1 | Instruction path capture strobe |
| ir_shift | input | 1 | Instruction path shift strobe |
| ir_update | input | 1 | Instruction path update strobe |
| dr_capture | input | 1 | Data path capture strobe |
| dr_shift | input | 1 | Data path shift strobe |
| dr_update | input | 1 | Data path update strobe |
| tdo | output | 1 | Serial data out |

## Verification
The bench builds the block with BUSY_CYCLES set to 40 and ID_CODE set to 0x5A3C96E1. A busy window of 40 cycles is long enough to load a new instruction and capture the status byte while an operation is still running. This lets the bench check the busy flag on the last busy edge and again one edge later, and check that requests made during an operation are ignored. The asymmetric identification value exposes any error in shift direction or bit order.

// File: rtl/isc_flash_pkg.sv
package isc_flash_pkg;

    localparam int DATA_W = 64;
    localparam int SR_W   = 7;

    localparam logic [7:0] OPC_CFG_READ = 8'h07;
    localparam logic [7:0] OPC_MODE_ON  = 8'h0C;
    localparam logic [7:0] OPC_MODE_OFF = 8'h0F;
    localparam logic [7:0] OPC_STATUS   = 8'h10;
    localparam logic [7:0] OPC_ADDR     = 8'h11;
    localparam logic [7:0] OPC_CLEAR    = 8'h13;
    localparam logic [7:0] OPC_PROG     = 8'h20;
    localparam logic [7:0] OPC_SECURE   = 8'h22;
    localparam logic [7:0] OPC_ERASE    = 8'h30;
    localparam logic [7:0] OPC_BLANK    = 8'h60;
    localparam logic [7:0] OPC_IDCODE   = 8'hFE;

    localparam logic [7:0] OPT_ADDR      = 8'h50;
    localparam int         OPT_ERASE_BIT = 49;

    localparam logic [1:0] RES_NONE = 2'd0;
    localparam logic [1:0] RES_BAD  = 2'd1;
    localparam logic [1:0] RES_OK   = 2'd2;
    localparam logic [1:0] RES_OFF  = 2'd3;

    typedef enum logic [2:0] {
        SEL_BYPASS, SEL_STATUS, SEL_ADDR, SEL_DATA, SEL_ID
    } dr_sel_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_PROG, OP_SECURE, OP_ERASE, OP_BLANK
    } op_kind_e;

    typedef struct packed {
        logic       rsvd;
        logic       secure;
        logic [1:0] int_err;
        logic       mode_on;
        logic       done;
        logic [1:0] res;
    } status_t;

    function automatic dr_sel_e decode_sel(input logic [7:0] op);
        case (op)
            OPC_STATUS:                                  return SEL_STATUS;
            OPC_ADDR:                                    return SEL_ADDR;
            OPC_CFG_READ, OPC_PROG, OPC_ERASE, OPC_BLANK: return SEL_DATA;
            OPC_IDCODE:                                  return SEL_ID;
            default:                                     return SEL_BYPASS;
        endcase
    endfunction

    function automatic logic is_known(input logic [7:0] op);
        case (op)
            OPC_CFG_READ, OPC_MODE_ON, OPC_MODE_OFF, OPC_STATUS, OPC_ADDR,
            OPC_CLEAR, OPC_PROG, OPC_SECURE, OPC_ERASE, OPC_BLANK,
            OPC_IDCODE: return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [SR_W-1:0] sel_width(input dr_sel_e s);
        case (s)
            SEL_STATUS: return SR_W'(8);
            SEL_ADDR:   return SR_W'(8);
            SEL_DATA:   return SR_W'(DATA_W);
            SEL_ID:     return SR_W'(32);
            default:    return SR_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/isc_ir_unit.sv
module isc_ir_unit
    import isc_flash_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tdi,
    input  logic       ir_capture,
    input  logic       ir_shift,
    input  logic       ir_update,
    output logic [7:0] ir_cur,
    output logic [7:0] ir_next
);
    logic [7:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= 8'h00;
            ir_cur <= OPC_IDCODE;
        end else begin
            if (ir_capture)
                sr_q <= 8'h01;
            else if (ir_shift)
                sr_q <= {tdi, sr_q[7:1]};
            if (ir_update)
                ir_cur <= sr_q;
        end
    end

    assign ir_next = sr_q;
endmodule

// File: rtl/isc_dr_shift.sv
module isc_dr_shift
    import isc_flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tdi,
    input  logic              capture,
    input  logic              shift,
    input  logic [SR_W-1:0]   width,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] sr
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  msb;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        msb      = IDX_W'(width - SR_W'(1));
        nxt      = sr >> 1;
        nxt[msb] = tdi;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (capture)
            sr <= cap_val;
        else if (shift)
            sr <= nxt;
    end
endmodule

// File: rtl/isc_flash_core.sv
module isc_flash_core
    import isc_flash_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ir_update,
    input  logic [7:0]        ir_next,
    input  logic              dr_update,
    input  logic [7:0]        ir_cur,
    input  logic [DATA_W-1:0] dr_val,
    output status_t           status,
    output logic [DATA_W-1:0] options,
    output logic [DATA_W-1:0] blank_res,
    output logic [7:0]        addr,
    output logic              op_req
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic              mode_on, secure, done;
    logic [1:0]        res;
    logic [CNT_W-1:0]  cnt;
    op_kind_e          req_kind, pend_kind;
    logic [DATA_W-1:0] pend_data, dirty;
    logic [7:0]        pend_addr;

    always_comb begin
        req_kind = OP_NONE;
        if (ir_update && ir_next == OPC_SECURE)
            req_kind = OP_SECURE;
        else if (dr_update) begin
            case (ir_cur)
                OPC_PROG:  req_kind = OP_PROG;
                OPC_ERASE: req_kind = OP_ERASE;
                OPC_BLANK: req_kind = OP_BLANK;
                default:   req_kind = OP_NONE;
            endcase
        end
        op_req = (req_kind != OP_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_on   <= 1'b0;
            secure    <= 1'b0;
            done      <= 1'b1;
            res       <= RES_NONE;
            cnt       <= '0;
            pend_kind <= OP_NONE;
            pend_data <= '0;
            pend_addr <= '0;
            dirty     <= '0;
            options   <= '0;
            blank_res <= '0;
            addr      <= '0;
        end else begin
            if (dr_update && ir_cur == OPC_ADDR)
                addr <= dr_val[7:0];

            if (!done) begin
                if (cnt == '0) begin
                    done <= 1'b1;
                    res  <= RES_OK;
                    case (pend_kind)
                        OP_PROG: begin
                            if (pend_addr[7:6] == 2'b00)
                                dirty[pend_addr[5:0]] <= 1'b1;
                            else if (pend_addr == OPT_ADDR)
                                options <= pend_data;
                        end
                        OP_SECURE: secure <= 1'b1;
                        OP_ERASE: begin
                            if (&pend_data) begin
                                dirty   <= '0;
                                options <= '0;
                                secure  <= 1'b0;
                            end else if (pend_data == (DATA_W'(1) << OPT_ERASE_BIT))
                                options <= '0;
                            else
                                dirty <= dirty & ~pend_data;
                        end
                        OP_BLANK: blank_res <= dirty & pend_data;
                        default: ;
                    endcase
                end else
                    cnt <= cnt - CNT_W'(1);
            end

            if (ir_update) begin
                case (ir_next)
                    OPC_MODE_ON:  mode_on <= 1'b1;
                    OPC_MODE_OFF: mode_on <= 1'b0;
                    OPC_CLEAR:    if (done) res <= RES_NONE;
                    default:      if (done && !is_known(ir_next)) res <= RES_BAD;
                endcase
            end

            if (op_req && done) begin
                if (mode_on) begin
                    done      <= 1'b0;
                    cnt       <= CNT_W'(BUSY_CYCLES - 1);
                    pend_kind <= req_kind;
                    pend_data <= dr_val;
                    pend_addr <= addr;
                end else
                    res <= RES_OFF;
            end
        end
    end

    always_comb begin
        status         = '0;
        status.secure  = secure;
        status.mode_on = mode_on;
        status.done    = done;
        status.res     = res;
    end
endmodule

// File: rtl/isc_flash_tap_target.sv
module isc_flash_tap_target
    import isc_flash_pkg::*;
#(
    parameter logic [31:0] ID_CODE     = 32'h1234_5671,
    parameter int          BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tdi,
    input  logic ir_capture,
    input  logic ir_shift,
    input  logic ir_update,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic dr_update,
    output logic tdo
);
    logic [7:0]        ir_cur, ir_next, addr;
    logic [DATA_W-1:0] dr_sr, cap_val, options, blank_res;
    logic [SR_W-1:0]   width;
    dr_sel_e           sel;
    status_t           status;
    logic              op_req;

    isc_ir_unit u_ir (
        .clk(clk), .rst(rst), .tdi(tdi),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .ir_cur(ir_cur), .ir_next(ir_next)
    );

    always_comb begin
        sel   = decode_sel(ir_cur);
        width = sel_width(sel);
        case (sel)
            SEL_STATUS: cap_val = DATA_W'(status);
            SEL_ADDR:   cap_val = DATA_W'(addr);
            SEL_ID:     cap_val = DATA_W'(ID_CODE);
            SEL_DATA:   cap_val = (ir_cur == OPC_CFG_READ) ? options :
                                  (ir_cur == OPC_BLANK)    ? blank_res : '0;
            default:    cap_val = '0;
        endcase
    end

    isc_dr_shift u_dr (
        .clk(clk), .rst(rst), .tdi(tdi),
        .capture(dr_capture), .shift(dr_shift),
        .width(width), .cap_val(cap_val), .sr(dr_sr)
    );

    isc_flash_core #(.BUSY_CYCLES(BUSY_CYCLES)) u_core (
        .clk(clk), .rst(rst),
        .ir_update(ir_update), .ir_next(ir_next),
        .dr_update(dr_update), .ir_cur(ir_cur), .dr_val(dr_sr),
        .status(status), .options(options), .blank_res(blank_res),
        .addr(addr), .op_req(op_req)
    );

    assign tdo = ir_shift ? ir_next[0] : dr_sr[0];
endmodule

// File: rtl/isc_flash_tap_target_chk.sv
module isc_flash_tap_target_chk
    import isc_flash_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       ir_update,
    input logic [7:0] ir_next,
    input logic       op_req,
    input logic       done,
    input logic       mode_on,
    input logic [1:0] res
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (rst || done)
            busy_len <= 0;
        else
            busy_len <= busy_len + 1;
    end

    p_mode_on_r3: assert property (@(posedge clk) disable iff (rst)
        (ir_update && ir_next == OPC_MODE_ON) |=> mode_on);

    p_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
        (ir_update && ir_next == OPC_MODE_OFF) |=> !mode_on);

    p_reject_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (op_req && done && !mode_on) |=> (done && res == RES_OFF));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (op_req && done && mode_on) |=> !done);

    p_finish_ok_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> res == RES_OK);

    p_busy_bound_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> busy_len < BUSY_CYCLES);

    p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
        (ir_update && !is_known(ir_next) && done && !op_req) |=> res == RES_BAD);

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (op_req && !done && busy_len < BUSY_CYCLES - 1) |=> !done);
endmodule

bind isc_flash_tap_target isc_flash_tap_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .ir_update(ir_update), .ir_next(ir_next),
    .op_req(op_req), .done(status.done), .mode_on(status.mode_on), .res(status.res)
);

// File: tb/test_isc_flash_tap_target.sv
module test_isc_flash_tap_target;
    localparam int          B  = 40;
    localparam logic [31:0] ID = 32'h5A3C_96E1;

    logic clk = 1'b0, rst = 1'b1, tdi = 1'b0;
    logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
    logic tdo;
    int   n_chk = 0, n_bad = 0, cyc = 0, mark = 0;
    bit   ended = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isc_flash_tap_target #(.ID_CODE(ID), .BUSY_CYCLES(B)) i_isc_flash_tap_target (
        .clk(clk), .rst(rst), .tdi(tdi),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdo(tdo)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ir_load(input logic [7:0] op);
        @(negedge clk) ir_capture = 1'b1;
        @(negedge clk) ir_capture = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tdi = op[i]; ir_shift = 1'b1;
            @(negedge clk);
        end
        ir_shift = 1'b0; ir_update = 1'b1;
        @(negedge clk) ir_update = 1'b0;
    endtask

    task automatic dr_shift_bits(input int w, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < w; i++) begin
            tdi = din[i]; dr_shift = 1'b1;
            #1 dout[i] = tdo;
            @(negedge clk);
        end
        dr_shift = 1'b0;
    endtask

    task automatic dr_xfer(input int w, input logic [63:0] din, input bit upd,
                           output logic [63:0] dout);
        @(negedge clk) dr_capture = 1'b1;
        @(negedge clk) dr_capture = 1'b0;
        dr_shift_bits(w, din, dout);
        if (upd) begin
            dr_update = 1'b1;
            @(negedge clk) dr_update = 1'b0;
            mark = cyc;
        end
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [63:0] d;
        ir_load(8'h10);
        dr_xfer(8, 64'd0, 1'b0, d);
        s = d[7:0];
    endtask

    // status captured exactly n edges after the last start edge
    task automatic timed_status(input int n, output logic [7:0] s);
        logic [63:0] d;
        ir_load(8'h10);
        while (cyc < mark + n - 1) @(negedge clk);
        dr_capture = 1'b1;
        @(negedge clk) dr_capture = 1'b0;
        dr_shift_bits(8, 64'd0, d);
        s = d[7:0];
    endtask

    task automatic wait_idle;
        logic [7:0] s;
        for (int k = 0; k < 30; k++) begin
            read_status(s);
            if (s[2]) break;
        end
    endtask

    task automatic prog(input logic [7:0] a, input logic [63:0] data);
        logic [63:0] d;
        ir_load(8'h11);
        dr_xfer(8, 64'(a), 1'b1, d);
        ir_load(8'h20);
        dr_xfer(64, data, 1'b1, d);
    endtask

    task automatic read64(input logic [7:0] op, output logic [63:0] v);
        ir_load(op);
        dr_xfer(64, 64'd0, 1'b0, v);
    endtask

    task automatic t_reset;
        logic [63:0] d; logic [7:0] s;
        dr_xfer(32, 64'd0, 1'b0, d);
        check("R1 idcode after reset", d[31:0], 64'(ID));
        read_status(s);
        check("R1 R2 status after reset", s, 8'h04);
    endtask

    task automatic t_bypass_clear;
        logic [63:0] d; logic [7:0] s;
        ir_load(8'hAB);
        dr_xfer(2, 64'b01, 1'b0, d);
        check("R10 bypass one-bit path", d[1:0], 2'b10);
        read_status(s);
        check("R10 unknown sets result 1", s, 8'h05);
        ir_load(8'h13);
        read_status(s);
        check("R11 clear result", s, 8'h04);
    endtask

    task automatic t_reject_off;
        logic [7:0] s;
        prog(8'd3, 64'hFFFF);
        read_status(s);
        check("R8 program rejected when mode off", s, 8'h07);
    endtask

    task automatic t_program;
        logic [7:0] s; logic [63:0] v;
        ir_load(8'h0C);
        read_status(s);
        check("R3 mode enable", s, 8'h0F);
        prog(8'd5, 64'h1);
        timed_status(B, s);
        check("R9 still busy on last busy edge", 64'(s[2]), 64'd0);
        wait_idle();
        read_status(s);
        check("R9 R4 program completes ok", s, 8'h0E);
        prog(8'd40, 64'h2); wait_idle();
        prog(8'd49, 64'h3); wait_idle();
        prog(8'h50, 64'hC0DE_1234_5678_9ABC); wait_idle();
        read64(8'h07, v);
        check("R4 option word readback", v, 64'hC0DE_1234_5678_9ABC);
    endtask

    task automatic t_blank;
        logic [7:0] s; logic [63:0] d;
        ir_load(8'h60);
        dr_xfer(64, '1, 1'b1, d);
        timed_status(B + 1, s);
        check("R9 done one edge after busy window", s, 8'h0E);
        read64(8'h60, d);
        check("R5 blank check result", d, (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 49));
    endtask

    task automatic t_busy_ignore;
        logic [7:0] s; logic [63:0] d;
        ir_load(8'h30);
        dr_xfer(64, 64'd1 << 5, 1'b1, d);
        ir_load(8'h22);
        wait_idle();
        read_status(s);
        check("R12 security request while busy ignored", s, 8'h0E);
        ir_load(8'h60); dr_xfer(64, '1, 1'b1, d); wait_idle();
        read64(8'h60, d);
        check("R6 sector erase by mask", d, (64'd1 << 40) | (64'd1 << 49));
    endtask

    task automatic t_opt_erase;
        logic [63:0] d;
        ir_load(8'h30); dr_xfer(64, 64'd1 << 49, 1'b1, d); wait_idle();
        read64(8'h07, d);
        check("R6 bit49 mask clears option word", d, 64'd0);
        ir_load(8'h60); dr_xfer(64, '1, 1'b1, d); wait_idle();
        read64(8'h60, d);
        check("R6 bit49 mask leaves sectors", d, (64'd1 << 40) | (64'd1 << 49));
    endtask

    task automatic t_secure_full;
        logic [7:0] s; logic [63:0] d;
        ir_load(8'h22); wait_idle();
        read_status(s);
        check("R7 security flag set", s, 8'h4E);
        prog(8'h50, 64'h55AA); wait_idle();
        ir_load(8'h30); dr_xfer(64, '1, 1'b1, d); wait_idle();
        read_status(s);
        check("R6 full erase clears security", s, 8'h0E);
        ir_load(8'h60); dr_xfer(64, '1, 1'b1, d); wait_idle();
        read64(8'h60, d);
        check("R6 full erase clears sectors", d, 64'd0);
        read64(8'h07, d);
        check("R6 full erase clears options", d, 64'd0);
    endtask

    task automatic t_disable;
        logic [7:0] s; logic [63:0] d;
        ir_load(8'h0F);
        read_status(s);
        check("R3 mode disable", s, 8'h06);
        ir_load(8'h30); dr_xfer(64, '1, 1'b1, d);
        read_status(s);
        check("R8 erase rejected when mode off", s, 8'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass_clear();
        t_reject_off();
        t_program();
        t_blank();
        t_busy_ignore();
        t_opt_erase();
        t_secure_full();
        t_disable();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule